// File: doc/BRIEF.md
# Serial flash command front-end

This block is the target-side serial front-end of a NOR flash device. It watches chip enable, the serial clock and four IO lines, and it oversamples all of them in a faster system clock domain. It assembles instruction bytes from the line and tracks which framing is active: single-line or four-line. The first complete byte of each selection goes to a downstream decoder as an opcode strobe. Every later byte in the same selection is handed over as a generic data byte. The block handles the two framing-change opcodes itself.

On the transmit side, the downstream logic presents a byte and raises a transmit-enable level. The block launches that byte on falling serial-clock edges, one bit or one nibble at a time. It drives the output enables only while it actually owns the lines. In single-line framing IO3 acts as an active-low hold input. Hold pauses the bit sequence and floats the output without losing the position reached. The block accepts no instruction after power-up until chip enable has gone from high to low.

Top module: `sflash_cmd_front`

## Requirements
- R1: After hardware reset, `qpiMode` is 0, `ioOe` is 0 and no strobe is issued.
- R2: After reset, no byte is accepted until `ceN` has been seen going from 1 to 0. Clocking with `ceN` held low since reset yields no strobe.
- R3: In single-line framing, bits are sampled on rising `sckIn` edges from `ioIn[0]`, most significant bit first. The first byte of a selection gives a one-cycle `opValid` pulse with the byte on `rxByte`. Each further byte in the same selection gives a one-cycle `byteValid` pulse instead.
- R4: Opcode 0x35 received in single-line framing sets `qpiMode` to 1. It still produces its `opValid` strobe.
- R5: In four-line framing, a byte takes two rising edges. The high nibble comes first, and `ioIn[3]` carries the most significant bit of each nibble.
- R6: Opcode 0xF5 received in four-line framing clears `qpiMode`. 0xF5 in single-line framing and 0x35 in four-line framing leave the mode unchanged.
- R7: A `swReset` pulse or a hardware reset (`rstN` low) returns `qpiMode` to 0.
- R8: While `ceN` is 1, input is ignored and `ioOe` is 0. A `ceN` rise in the middle of a byte discards the partial bits, and no strobe is issued for them.
- R9: With `txEn` high, each falling `sckIn` edge launches the next piece of `txByte`, most significant first. In single-line framing the piece is one bit on `ioOut[1]` with `ioOe`=4'b0010. In four-line framing it is a nibble on `ioOut[3:0]` with `ioOe`=4'b1111. `txTake` pulses once per byte, after its last piece.
- R10: In single-line framing while selected, `ioIn[3]`=0 (hold) forces `ioOe` to 0 and makes the block ignore serial-clock edges. The sequence continues from the same bit once `ioIn[3]` returns to 1.
- R11: Reception and transmission behave the same whether `sckIn` idles low or idles high between selections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sckIn |
| rstN | input | 1 | Active-low hardware reset |
| swReset | input | 1 | Software reset strobe from the decoder |
| sckIn | input | 1 | Serial clock from the host |
| ceN | input | 1 | Active-low chip enable |
| ioIn | input | 4 | IO line inputs; IO3 is hold in single-line framing |
| txByte | input | 8 | Byte to transmit |
| txEn | input | 1 | Transmit request level |
| opValid | output | 1 | One-cycle strobe: opcode on rxByte |
| byteValid | output | 1 | One-cycle strobe: data byte on rxByte |
| rxByte | output | 8 | Last received byte |
| qpiMode | output | 1 | 1 when four-line framing is active |
| txTake | output | 1 | One-cycle strobe: txByte fully launched |
| ioOut | output | 4 | IO line output values |
| ioOe | output | 4 | Per-line output enables |

## Verification
A mode register that is wrong misframes the very next instruction. The wrong byte shows on `rxByte` at the opcode strobe, at most eight serial-clock edges later. A bit or nibble counter that has slipped shifts every following byte. A counter that is not cleared when the device is deselected leaks stale bits into the next opcode. Both faults show at the first strobe after the fault. Errors in the arming or hold state appear at once as a strobe that should not occur, or as output enables that are on while deselected or held.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] OP_ENTER_QUAD = 8'h35;
  localparam logic [7:0] OP_EXIT_QUAD  = 8'hF5;
  localparam int NIB_W = 4;

  typedef enum logic {MODE_SINGLE = 1'b0, MODE_QUAD = 1'b1} busMode_e;

  typedef struct packed {
    logic sampleEn;  // rising serial edge to be taken
    logic launchEn;  // falling serial edge to be taken
    logic clearSeq;  // deselected: drop sequence state
    logic quad;      // four-line framing active
  } seqCtl_t;
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL[b]}};
        else       chain <= {chain[STAGES-2:0], din[b]};
      end
      assign dout[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckS,
  input  logic       ceS,
  input  logic       holdS,
  input  logic       swReset,
  input  logic       opValid,
  input  logic [7:0] opcode,
  output seqCtl_t    ctl,
  output logic       selected,
  output logic       paused,
  output logic       qpiMode
);
  logic sckD, ceD, armed;
  busMode_e mode;
  logic riseEvt, fallEvt;

  assign riseEvt  = sckS & ~sckD;
  assign fallEvt  = ~sckS & sckD;
  assign selected = armed & ~ceS;
  assign paused   = selected & (mode == MODE_SINGLE) & ~holdS;
  assign qpiMode  = (mode == MODE_QUAD);

  always_comb begin
    ctl.sampleEn = selected & ~paused & riseEvt;
    ctl.launchEn = selected & ~paused & fallEvt;
    ctl.clearSeq = ~selected;
    ctl.quad     = (mode == MODE_QUAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckD  <= 1'b0;
      ceD   <= 1'b0;
      armed <= 1'b0;
      mode  <= MODE_SINGLE;
    end else begin
      sckD <= sckS;
      ceD  <= ceS;
      if (ceD && !ceS) armed <= 1'b1;
      if (swReset) begin
        mode <= MODE_SINGLE;
      end else if (opValid) begin
        if (mode == MODE_SINGLE && opcode == OP_ENTER_QUAD) mode <= MODE_QUAD;
        else if (mode == MODE_QUAD && opcode == OP_EXIT_QUAD) mode <= MODE_SINGLE;
      end
    end
  end
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              selected,
  input  logic              paused,
  input  logic [NIB_W-1:0]  ioS,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txEn,
  output logic              opValid,
  output logic              byteValid,
  output logic [DATA_W-1:0] rxByte,
  output logic              txTake,
  output logic [NIB_W-1:0]  ioOut,
  output logic [NIB_W-1:0]  ioOe
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0] rxShift, shiftNext, txShifted;
  logic [CNT_W-1:0]  rxCnt, txIdx, step, rxCntNext, txIdxNext;
  logic              gotOp, txActive;
  logic [NIB_W-1:0]  outReg, pieceNext;

  assign step      = ctl.quad ? CNT_W'(NIB_W) : CNT_W'(1);
  assign rxCntNext = rxCnt + step;
  assign txIdxNext = txIdx + step;
  assign txShifted = txByte << txIdx;

  always_comb begin
    if (ctl.quad) begin
      shiftNext = {rxShift[DATA_W-NIB_W-1:0], ioS};
      pieceNext = txShifted[DATA_W-1 -: NIB_W];
    end else begin
      shiftNext = {rxShift[DATA_W-2:0], ioS[0]};
      pieceNext = {2'b00, txShifted[DATA_W-1], 1'b0};
    end
  end

  always_comb begin
    if (txActive && txEn && selected && !paused) begin
      ioOe  = ctl.quad ? {NIB_W{1'b1}} : NIB_W'(4'b0010);
      ioOut = outReg;
    end else begin
      ioOe  = '0;
      ioOut = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      rxCnt     <= '0;
      rxByte    <= '0;
      gotOp     <= 1'b0;
      opValid   <= 1'b0;
      byteValid <= 1'b0;
      txIdx     <= '0;
      txActive  <= 1'b0;
      txTake    <= 1'b0;
      outReg    <= '0;
    end else begin
      opValid   <= 1'b0;
      byteValid <= 1'b0;
      txTake    <= 1'b0;
      if (ctl.clearSeq) begin
        rxCnt    <= '0;
        gotOp    <= 1'b0;
        txIdx    <= '0;
        txActive <= 1'b0;
      end else begin
        if (ctl.sampleEn) begin
          rxShift <= shiftNext;
          if (rxCntNext == FULL) begin
            rxCnt     <= '0;
            rxByte    <= shiftNext;
            opValid   <= ~gotOp;
            byteValid <= gotOp;
            gotOp     <= 1'b1;
          end else begin
            rxCnt <= rxCntNext;
          end
        end
        if (ctl.launchEn && txEn) begin
          txActive <= 1'b1;
          outReg   <= pieceNext;
          if (txIdxNext == FULL) begin
            txIdx  <= '0;
            txTake <= 1'b1;
          end else begin
            txIdx <= txIdxNext;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic              sckIn,
  input  logic              ceN,
  input  logic [3:0]        ioIn,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txEn,
  output logic              opValid,
  output logic              byteValid,
  output logic [DATA_W-1:0] rxByte,
  output logic              qpiMode,
  output logic              txTake,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe
);
  localparam int SYNC_W = NIB_W + 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1000, 1'b0, 1'b0};

  logic [SYNC_W-1:0] syncOut;
  logic sckS, ceS, selected, paused;
  logic [NIB_W-1:0] ioS;
  seqCtl_t ctl;

  sfc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .din({ioIn, ceN, sckIn}), .dout(syncOut)
  );
  assign {ioS, ceS, sckS} = syncOut;

  sfc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sckS(sckS), .ceS(ceS), .holdS(ioS[3]),
    .swReset(swReset), .opValid(opValid), .opcode(rxByte[7:0]),
    .ctl(ctl), .selected(selected), .paused(paused), .qpiMode(qpiMode)
  );

  sfc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .selected(selected), .paused(paused),
    .ioS(ioS), .txByte(txByte), .txEn(txEn), .opValid(opValid),
    .byteValid(byteValid), .rxByte(rxByte), .txTake(txTake),
    .ioOut(ioOut), .ioOe(ioOe)
  );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       swReset,
  input logic       ceN,
  input logic       opValid,
  input logic       byteValid,
  input logic [7:0] rxByte,
  input logic       qpiMode,
  input logic [3:0] ioOe
);
  logic [1:0] rstAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstAge <= '0;
    else if (rstAge != 2'd3) rstAge <= rstAge + 2'd1;
  end

  a_r3_op_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid);
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && byteValid));
  a_r4_enter_quad: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && rxByte == 8'h35 && !qpiMode && !swReset) |=> qpiMode);
  a_r6_exit_quad: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && rxByte == 8'hF5 && qpiMode && !swReset) |=> !qpiMode);
  a_r6_mode_cause: assert property (@(posedge clk) disable iff (!rstN)
    (qpiMode != $past(qpiMode)) |-> ($past(opValid) || $past(swReset)));
  a_r7_sw_reset: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> !qpiMode);
  a_r8_oe_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe != 4'h0) |-> (rstAge == 2'd3 && !$past(ceN, 2)));
  a_r9_oe_shape: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe != 4'h0) |-> (qpiMode ? ioOe == 4'hF : ioOe == 4'h2));
endmodule

bind sflash_cmd_front sfc_checker u_sfc_checker (
  .clk(clk), .rstN(rstN), .swReset(swReset), .ceN(ceN), .opValid(opValid),
  .byteValid(byteValid), .rxByte(rxByte), .qpiMode(qpiMode), .ioOe(ioOe)
);

// File: tb/sflash_cmd_front_bench.sv
`timescale 1ns/1ps
module sflash_cmd_front_bench;
  localparam int HALF = 8;
  // bit 8: sck idles high; bits 7:0: opcode
  localparam logic [8:0] VECS [6] = '{9'h09F, 9'h105, 9'h0A5, 9'h15A, 9'h0FF, 9'h100};

  logic clk = 1'b0;
  logic rstN = 1'b0, swReset = 1'b0, sckIn = 1'b0, ceN = 1'b0, txEn = 1'b0;
  logic [3:0] ioIn = 4'b1000;
  logic [7:0] txByte = 8'h00;
  logic opValid, byteValid, qpiMode, txTake;
  logic [7:0] rxByte;
  logic [3:0] ioOut, ioOe;
  logic idleHigh = 1'b0;
  int checks = 0, errors = 0, opCnt = 0, byteCnt = 0, takeCnt = 0;
  logic [7:0] lastOp = 8'h00, lastData = 8'h00;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sflash_cmd_front u_sflash_cmd_front (
    .clk(clk), .rstN(rstN), .swReset(swReset), .sckIn(sckIn), .ceN(ceN),
    .ioIn(ioIn), .txByte(txByte), .txEn(txEn), .opValid(opValid),
    .byteValid(byteValid), .rxByte(rxByte), .qpiMode(qpiMode),
    .txTake(txTake), .ioOut(ioOut), .ioOe(ioOe)
  );

  always @(posedge clk) begin
    if (opValid)   begin opCnt++;   lastOp = rxByte;   end
    if (byteValid) begin byteCnt++; lastData = rxByte; end
    if (txTake)    takeCnt++;
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic selectDev();
    ceN = 1'b0; waitClk(6);
  endtask

  task automatic deselectDev();
    sckIn = idleHigh; waitClk(HALF);
    ceN = 1'b1; waitClk(HALF);
  endtask

  task automatic spiByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sckIn = 1'b0; ioIn[0] = v[i]; waitClk(HALF);
      sckIn = 1'b1; waitClk(HALF);
    end
  endtask

  task automatic quadByte(input logic [7:0] v);
    for (int i = 1; i >= 0; i--) begin
      sckIn = 1'b0; ioIn = v[i*4 +: 4]; waitClk(HALF);
      sckIn = 1'b1; waitClk(HALF);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int opBase, byteBase, takeBase;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // R1: reset state
    chk("R1 qpiMode", qpiMode, 0);
    chk("R1 ioOe", ioOe, 0);
    chk("R1 no strobe", opCnt, 0);
    // R2: chip enable low since reset, never armed
    spiByte(8'h9F);
    waitClk(HALF);
    chk("R2 no opcode before ce fall", opCnt, 0);
    sckIn = 1'b0; ceN = 1'b1; waitClk(HALF);

    // R3, R11: table of single-line opcodes in both clock idle levels
    for (int v = 0; v < 6; v++) begin
      idleHigh = VECS[v][8];
      sckIn = idleHigh; waitClk(HALF);
      opBase = opCnt;
      selectDev();
      spiByte(VECS[v][7:0]);
      deselectDev();
      chk("R3 R11 one opcode strobe", opCnt - opBase, 1);
      chk("R3 R11 opcode value", lastOp, VECS[v][7:0]);
    end
    idleHigh = 1'b0; sckIn = 1'b0; waitClk(HALF);

    // R3: later bytes of a selection are data
    opBase = opCnt; byteBase = byteCnt;
    selectDev(); spiByte(8'h03); spiByte(8'h12); spiByte(8'h34); deselectDev();
    chk("R3 opcode count", opCnt - opBase, 1);
    chk("R3 data count", byteCnt - byteBase, 2);
    chk("R3 last data", lastData, 8'h34);

    // R8: chip enable rise mid-byte discards partial bits
    opBase = opCnt;
    selectDev();
    for (int i = 0; i < 4; i++) begin
      sckIn = 1'b0; ioIn[0] = 1'b1; waitClk(HALF); sckIn = 1'b1; waitClk(HALF);
    end
    deselectDev();
    chk("R8 partial byte dropped", opCnt - opBase, 0);
    selectDev(); spiByte(8'h66); deselectDev();
    chk("R8 fresh byte after abort", lastOp, 8'h66);
    // R8: clocking while deselected is ignored
    opBase = opCnt;
    spiByte(8'hAB); spiByte(8'hCD);
    sckIn = 1'b0; waitClk(HALF);
    chk("R8 ignored while deselected", opCnt - opBase, 0);
    chk("R8 ioOe off while deselected", ioOe, 0);

    // R10: hold freezes the input sequence
    selectDev();
    for (int i = 7; i >= 4; i--) begin
      sckIn = 1'b0; ioIn[0] = 8'hC3 >> i; waitClk(HALF); sckIn = 1'b1; waitClk(HALF);
    end
    ioIn[3] = 1'b0; waitClk(HALF);
    for (int i = 0; i < 4; i++) begin
      sckIn = 1'b0; ioIn[0] = 1'b1; waitClk(HALF); sckIn = 1'b1; waitClk(HALF);
    end
    ioIn[3] = 1'b1; waitClk(HALF);
    for (int i = 3; i >= 0; i--) begin
      sckIn = 1'b0; ioIn[0] = 8'hC3 >> i; waitClk(HALF); sckIn = 1'b1; waitClk(HALF);
    end
    waitClk(HALF);
    chk("R10 byte resumed across hold", lastOp, 8'hC3);
    deselectDev();

    // R9: single-line transmit on falling edges
    takeBase = takeCnt;
    selectDev(); spiByte(8'h0B);
    txByte = 8'hA6; txEn = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sckIn = 1'b0; waitClk(HALF);
      chk("R9 single oe", ioOe, 4'h2);
      chk("R9 single bit", ioOut[1], txByte[i]);
      sckIn = 1'b1; waitClk(HALF);
    end
    chk("R9 take after byte", takeCnt - takeBase, 1);
    // R10: hold floats the output
    ioIn[3] = 1'b0; waitClk(HALF);
    chk("R10 oe off in hold", ioOe, 0);
    ioIn[3] = 1'b1; waitClk(HALF);
    chk("R10 oe back after hold", ioOe, 4'h2);
    deselectDev(); txEn = 1'b0;
    chk("R8 oe off after deselect", ioOe, 0);

    // R4: enter four-line framing
    opBase = opCnt;
    selectDev(); spiByte(8'h35); deselectDev();
    chk("R4 qpiMode set", qpiMode, 1);
    chk("R4 strobe for 0x35", lastOp, 8'h35);

    // R5, R9: four-line receive and transmit
    takeBase = takeCnt;
    selectDev(); quadByte(8'h6B);
    waitClk(HALF);
    chk("R5 quad opcode", lastOp, 8'h6B);
    txByte = 8'h5C; txEn = 1'b1;
    sckIn = 1'b0; waitClk(HALF);
    chk("R9 quad oe", ioOe, 4'hF);
    chk("R9 quad high nibble", ioOut, 4'h5);
    sckIn = 1'b1; waitClk(HALF);
    sckIn = 1'b0; waitClk(HALF);
    chk("R9 quad low nibble", ioOut, 4'hC);
    sckIn = 1'b1; waitClk(HALF);
    chk("R9 quad take", takeCnt - takeBase, 1);
    deselectDev(); txEn = 1'b0; ioIn = 4'b1000;

    // R6: 0x35 in quad keeps mode; 0xF5 exits; 0xF5 in single keeps mode
    selectDev(); quadByte(8'h35); deselectDev(); ioIn = 4'b1000;
    chk("R6 0x35 in quad no change", qpiMode, 1);
    selectDev(); quadByte(8'hF5); deselectDev(); ioIn = 4'b1000;
    chk("R6 0xF5 exits quad", qpiMode, 0);
    selectDev(); spiByte(8'hF5); deselectDev();
    chk("R6 0xF5 in single no change", qpiMode, 0);

    // R7: software and hardware reset
    selectDev(); spiByte(8'h35); deselectDev();
    swReset = 1'b1; waitClk(1); swReset = 1'b0; waitClk(2);
    chk("R7 software reset", qpiMode, 0);
    selectDev(); spiByte(8'h35); deselectDev();
    rstN = 1'b0; waitClk(3); rstN = 1'b1; waitClk(5);
    chk("R7 hardware reset", qpiMode, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule